// File: doc/BRIEF.md
# Row/Column Multiplexed DRAM Access Controller

This block connects a simple requester to an asynchronous dynamic RAM that takes its address in two halves over shared pins. For each accepted request it runs one complete cycle. The upper half of the address goes out first and is latched by the falling row strobe. The lower half follows and is latched by the falling column strobe. The write strobe and the outgoing data bus are set up before the column strobe falls. Read data is taken only once the programmed access time has run. Both strobes then return high, and a programmed precharge interval passes before the next cycle may start. No row is ever reused from one access to the next.

A timer inside the block raises a refresh request at a fixed interval. At the next idle point, a refresh is started before any waiting request is granted. A refresh lowers the column strobe first and then the row strobe, and it needs no address. The requester sees the block as busy while a refresh runs.

The row-to-column delay, the minimum row and column strobe widths, the access time and the precharge time are all run-time cycle counts. The requester changes them only while the block is held in reset.

Top module: `dram_mux_ctl`

## Requirements
- R1: The upper ROW_W bits of the request address are on `dram_addr` in the cycle before `dram_ras_n` falls, and they stay there in the cycle in which it falls.
- R2: For an access, the lower COL_W bits are placed on `dram_addr` one cycle before `dram_cas_n` falls. `dram_cas_n` falls only while `dram_ras_n` is already low, and the address is unchanged in the cycle CAS falls.
- R3: Read data is sampled from `dram_dq_in` only after `dram_ras_n` has been low for at least `cfg_acc` cycles. It appears on `rsp_rdata` together with `rsp_done`, which is high for exactly one cycle for every read and every write.
- R4: Every access ends with both strobes high, and each new access performs its own row strobe fall. While `busy` is low, both strobes are high and `dram_dq_oe` is low.
- R5: Each low pulse of `dram_ras_n` lasts at least `cfg_ras` cycles, and each low pulse of `dram_cas_n` lasts at least `cfg_cas` cycles.
- R6: Between any rise and the next fall of `dram_ras_n`, the strobe stays high for at least `cfg_rp` cycles.
- R7: Refresh runs without any requester action. Starts of successive refreshes are no more than REF_INTERVAL cycles plus one access apart. Each refresh lowers `dram_cas_n` one cycle before `dram_ras_n` (a falling RAS while CAS is already low).
- R8: A due refresh is started before a waiting request is granted, so constant traffic cannot starve it. During a refresh, `busy` is 1 and `req_ready` is 0.
- R9: For a write, `dram_we_n` is low and `dram_dq_oe` is 1, with the data on `dram_dq_out`, in the cycle before `dram_cas_n` falls and in the cycle it falls. `dram_dq_oe` is 0 whenever RAS is high.
- R10: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only when idle with no refresh due. A `req_valid` held while busy starts no cycle and writes nothing.
- R11: While `rst` is 1, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are 1, `dram_dq_oe`, `busy` and `rsp_done` are 0. After release, `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rcd | input | CNT_W | Cycles from RAS fall until the column address is presented |
| cfg_cas | input | CNT_W | Minimum CAS low width in cycles |
| cfg_ras | input | CNT_W | Minimum RAS low width in cycles |
| cfg_acc | input | CNT_W | Access time: RAS-low cycles before read data is sampled |
| cfg_rp | input | CNT_W | Minimum RAS high (precharge) cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full word address (row = upper half) |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| busy | output | 1 | An access or refresh is in progress |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the memory |
| dram_dq_oe | output | 1 | Output enable for dram_dq_out (0 = high impedance) |
| dram_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The row/column split is exercised with pairs of addresses whose two halves are swapped, such as row 5/column 3 against row 3/column 5, and with a pair that shares a row but differs in column. A mixed-up half or a dropped bit would make these pairs alias. All-ones and all-zeros addresses and data show any stuck bit. The behavioural memory returns inverted data until the access time has elapsed, so sampling even one cycle early is caught. It also measures every strobe width and precharge gap against the programmed counts. The same patterns are repeated under a second timing set. An idle stretch and a long back-to-back stream separate refresh that is timed by hardware and scheduled with priority from refresh that is late or starved. A request held during a busy period must leave both the access count and the untouched location unchanged.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RCD,
        ST_COL,
        ST_CAS,
        ST_PRE,
        ST_RFC,
        ST_RFR
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic dq_oe;
        logic col_sel;
    } pin_ctl_t;

    // True once a state that has run (elapsed+1) cycles has met the limit.
    function automatic logic reached(input logic [15:0] elapsed,
                                     input logic [15:0] limit);
        return (elapsed + 16'd1) >= limit;
    endfunction

    function automatic pin_ctl_t pins_for(input seq_state_e st, input logic wr);
        pin_ctl_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0, col_sel: 1'b0};
        case (st)
            ST_RCD: p.ras_n = 1'b0;
            ST_COL: begin
                p.ras_n = 1'b0;
                p.col_sel = 1'b1;
                p.we_n = ~wr;
                p.dq_oe = wr;
            end
            ST_CAS: begin
                p.ras_n = 1'b0;
                p.cas_n = 1'b0;
                p.col_sel = 1'b1;
                p.we_n = ~wr;
                p.dq_oe = wr;
            end
            ST_RFC: p.cas_n = 1'b0;
            ST_RFR: begin
                p.ras_n = 1'b0;
                p.cas_n = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 1560,
    localparam int TW = $clog2(INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick    <= '0;
            pending <= 1'b0;
        end else begin
            if (ack) pending <= 1'b0;
            if (tick == TW'(INTERVAL - 1)) begin
                tick    <= '0;
                pending <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_mux_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             wr_q,
    input  logic             ref_pending,
    input  logic [CNT_W-1:0] cfg_rcd,
    input  logic [CNT_W-1:0] cfg_cas,
    input  logic [CNT_W-1:0] cfg_ras,
    input  logic [CNT_W-1:0] cfg_acc,
    input  logic [CNT_W-1:0] cfg_rp,
    output pin_ctl_t         pins,
    output logic             ready,
    output logic             accept,
    output logic             ref_ack,
    output logic             capture,
    output logic             busy
);
    seq_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, ras_cnt;
    logic             cas_ok, rfr_ok;

    assign pins    = pins_for(state, wr_q);
    assign ready   = (state == ST_IDLE) && !ref_pending;
    assign accept  = ready && req_valid;
    assign ref_ack = (state == ST_IDLE) && ref_pending;
    assign busy    = (state != ST_IDLE);

    assign cas_ok = reached(16'(cnt), 16'(cfg_cas)) &&
                    reached(16'(ras_cnt), 16'(cfg_ras)) &&
                    reached(16'(ras_cnt), 16'(cfg_acc));
    assign rfr_ok = reached(16'(ras_cnt), 16'(cfg_ras)) &&
                    reached(16'(ras_cnt), 16'(cfg_cas));

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (ref_pending) nxt = ST_RFC;
                     else if (req_valid) nxt = ST_ROW;
            ST_ROW:  nxt = ST_RCD;
            ST_RCD:  if (reached(16'(cnt), 16'(cfg_rcd))) nxt = ST_COL;
            ST_COL:  nxt = ST_CAS;
            ST_CAS:  if (cas_ok) nxt = ST_PRE;
            ST_PRE:  if (reached(16'(cnt), 16'(cfg_rp))) nxt = ST_IDLE;
            ST_RFC:  nxt = ST_RFR;
            ST_RFR:  if (rfr_ok) nxt = ST_PRE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign capture = (state == ST_CAS) && (nxt == ST_PRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            ras_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)    cnt <= '0;
            else if (cnt != '1)  cnt <= cnt + 1'b1;
            if (nxt != state && (nxt == ST_RCD || nxt == ST_RFR))
                ras_cnt <= '0;
            else if (!pins.ras_n && ras_cnt != '1)
                ras_cnt <= ras_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dram_mux_ctl.sv
module dram_mux_ctl
    import dram_mux_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 4,
    parameter int REF_INTERVAL = 1560,
    localparam int COL_W = ADDR_W / 2,
    localparam int ROW_W = ADDR_W - COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_rcd,
    input  logic [CNT_W-1:0]  cfg_cas,
    input  logic [CNT_W-1:0]  cfg_ras,
    input  logic [CNT_W-1:0]  cfg_acc,
    input  logic [CNT_W-1:0]  cfg_rp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_in
);
    logic              ref_pending, ref_ack, accept, capture;
    pin_ctl_t          pins;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    dram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pending)
    );

    dram_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .wr_q(wr_q),
        .ref_pending(ref_pending),
        .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas), .cfg_ras(cfg_ras),
        .cfg_acc(cfg_acc), .cfg_rp(cfg_rp),
        .pins(pins), .ready(req_ready), .accept(accept), .ref_ack(ref_ack),
        .capture(capture), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            rsp_done <= capture;
            if (capture && !wr_q) rsp_rdata <= dram_dq_in;
        end
    end

    assign dram_addr   = pins.col_sel ? ROW_W'(addr_q[COL_W-1:0])
                                      : addr_q[ADDR_W-1:COL_W];
    assign dram_ras_n  = pins.ras_n;
    assign dram_cas_n  = pins.cas_n;
    assign dram_we_n   = pins.we_n;
    assign dram_dq_oe  = pins.dq_oe;
    assign dram_dq_out = wdata_q;
endmodule

// File: rtl/dram_mux_chk.sv
module dram_mux_chk #(
    parameter int CNT_W = 4,
    parameter int ROW_W = 10,
    localparam int W = CNT_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic [ROW_W-1:0] addr,
    input logic             done,
    input logic             ready,
    input logic             busy,
    input logic [CNT_W-1:0] cfg_ras,
    input logic [CNT_W-1:0] cfg_cas,
    input logic [CNT_W-1:0] cfg_rp
);
    logic [W-1:0] ras_low, cas_low, ras_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_low  <= '0;
            cas_low  <= '0;
            ras_high <= '1;
        end else begin
            ras_low  <= ras_n ? '0 : ((ras_low == '1) ? ras_low : ras_low + 1'b1);
            cas_low  <= cas_n ? '0 : ((cas_low == '1) ? cas_low : cas_low + 1'b1);
            ras_high <= !ras_n ? '0 : ((ras_high == '1) ? ras_high : ras_high + 1'b1);
        end
    end

    assert_row_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && cas_n) |-> $stable(addr));

    assert_cas_after_ras_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n) |-> (!$past(ras_n) && $stable(addr)));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ras_n && cas_n && !dq_oe));

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (ras_low >= W'(cfg_ras)));

    assert_cas_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> (cas_low >= W'(cfg_cas)));

    assert_precharge_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (ras_high >= W'(cfg_rp)));

    assert_refresh_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (!cas_n && ras_n) |-> (busy && !ready));

    assert_write_setup_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n && !we_n) |-> (!$past(we_n) && dq_oe));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
        ready |-> !busy);
endmodule

bind dram_mux_ctl dram_mux_chk #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .dq_oe(dram_dq_oe), .addr(dram_addr),
    .done(rsp_done), .ready(req_ready), .busy(busy),
    .cfg_ras(cfg_ras), .cfg_cas(cfg_cas), .cfg_rp(cfg_rp)
);

// File: tb/sim_dram_mux_ctl.sv
module sim_dram_mux_ctl;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;
    localparam int REF_IV = 100;
    localparam int HALF   = 6;
    localparam int GAP_MAX = REF_IV + 24;

    logic clk = 0;
    logic rst = 1;
    logic [CNT_W-1:0] cfg_rcd = 2, cfg_cas = 2, cfg_ras = 5, cfg_acc = 4, cfg_rp = 3;
    logic req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_done, busy;
    logic [DATA_W-1:0] rsp_rdata, dq_out;
    logic [DATA_W-1:0] dq_in = '0;
    logic [HALF-1:0] dram_addr;
    logic ras_n, cas_n, we_n, dq_oe;

    always #4 clk = ~clk;

    dram_mux_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                   .REF_INTERVAL(REF_IV)) u0 (
        .clk(clk), .rst(rst), .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas),
        .cfg_ras(cfg_ras), .cfg_acc(cfg_acc), .cfg_rp(cfg_rp),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .busy(busy), .dram_addr(dram_addr),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    int n_checks = 0, n_err = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural memory, sampled on the falling clock edge
    logic [DATA_W-1:0] mem [int];
    int cyc = 0, rlow = 0, clow = 0, rhigh = 1000;
    int acc_cnt = 0, ref_cnt = 0, last_ref = 0, max_gap = 0;
    int viol_w = 0, viol_rp = 0, viol_oe = 0, viol_ord = 0;
    logic prev_ras = 1, prev_cas = 1, prev_we = 1;
    logic [HALF-1:0] m_row = '0, m_col = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_ras = 1; prev_cas = 1; prev_we = 1;
            rlow = 0; clow = 0; rhigh = 1000;
            last_ref = cyc;
            max_gap = 0;
        end else begin
            if (prev_ras && !ras_n) begin
                if (rhigh < int'(cfg_rp)) viol_rp++;
                if (cas_n) begin
                    m_row = dram_addr;
                    acc_cnt++;
                end else begin
                    ref_cnt++;
                    if (cyc - last_ref > max_gap) max_gap = cyc - last_ref;
                    last_ref = cyc;
                    if (!busy || req_ready) viol_ord++;
                end
                rlow = 0;
            end
            if (prev_cas && !cas_n) begin
                clow = 0;
                if (!ras_n) begin
                    m_col = dram_addr;
                    if (!we_n) begin
                        if (!dq_oe || prev_we) viol_oe++;
                        mem[int'({m_row, m_col})] = dq_out;
                    end
                end
            end
            if (!prev_ras && ras_n) begin
                if (rlow < int'(cfg_ras)) viol_w++;
                if (!cas_n) viol_ord++;
                rhigh = 0;
            end
            if (!prev_cas && cas_n && clow < int'(cfg_cas)) viol_w++;
            if (ras_n && dq_oe) viol_oe++;
            if (!ras_n) rlow++; else rhigh++;
            if (!cas_n) clow++;
            prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
        end
        begin
            logic [DATA_W-1:0] v;
            v = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : '0;
            dq_in = (!ras_n && !cas_n && rlow >= int'(cfg_acc)) ? v : ~v;
        end
    end

    task automatic do_access(input bit wr, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] q);
        int t;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        t = 0;
        while (!rsp_done && t < 200) begin @(negedge clk); t++; end
        check(rsp_done, "R3", "done seen", rsp_done, 1);
        q = rsp_rdata;
        @(negedge clk);
        check(!rsp_done, "R3", "done one cycle", rsp_done, 0);
    endtask

    function automatic string vec_name(input int i);
        return $sformatf("vector %0d", i);
    endfunction

    // {write, addr, data}: reads expect the data field
    localparam logic [28:0] VEC [12] = '{
        {1'b1, 12'h143, 16'h5A5A},
        {1'b1, 12'h0C5, 16'hA5A5},
        {1'b1, 12'h0C6, 16'h1234},
        {1'b1, 12'hFFF, 16'hFFFF},
        {1'b1, 12'h000, 16'h0000},
        {1'b0, 12'h0C5, 16'hA5A5},
        {1'b0, 12'h143, 16'h5A5A},
        {1'b0, 12'h0C6, 16'h1234},
        {1'b0, 12'hFFF, 16'hFFFF},
        {1'b0, 12'h000, 16'h0000},
        {1'b1, 12'h0C5, 16'hBEEF},
        {1'b0, 12'h0C5, 16'hBEEF}
    };

    task automatic check_protocol(input string tag);
        check(viol_w == 0, "R5", {tag, " strobe widths"}, viol_w, 0);
        check(viol_rp == 0, "R6", {tag, " precharge"}, viol_rp, 0);
        check(viol_oe == 0, "R9", {tag, " write setup / bus release"}, viol_oe, 0);
        check(viol_ord == 0, "R4", {tag, " strobe order / busy in refresh"}, viol_ord, 0);
    endtask

    initial begin
        #(8 * 150000);
        check(0, "all", "watchdog expired", 0, 1);
        if (!finished) begin
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] q;
        int a0, r0;
        // R11: reset state
        repeat (3) @(negedge clk);
        check(ras_n && cas_n && we_n, "R11", "strobes high in reset", {ras_n, cas_n, we_n}, 3'b111);
        check(!dq_oe && !busy && !rsp_done, "R11", "oe/busy/done low in reset", {dq_oe, busy, rsp_done}, 0);
        rst = 0;
        @(negedge clk);
        check(req_ready, "R11", "ready after reset", req_ready, 1);

        // Table walk, timing set A
        for (int i = 0; i < 12; i++) begin
            logic [28:0] v;
            v = VEC[i];
            do_access(v[28], v[27:16], v[15:0], q);
            check(m_row == v[27:16+HALF], "R1", {vec_name(i), " row"}, m_row, v[27:16+HALF]);
            check(m_col == v[16+HALF-1:16], "R2", {vec_name(i), " column"}, m_col, v[16+HALF-1:16]);
            if (!v[28]) check(q == v[15:0], "R3", {vec_name(i), " read data"}, q, v[15:0]);
        end
        check_protocol("set A");

        // R10: request held while busy is ignored
        a0 = acc_cnt;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h2AA; req_wdata = 16'h1111;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_addr = 12'h3BB; req_wdata = 16'h7777;
        for (int k = 0; k < 3; k++) begin
            check(busy && !req_ready, "R10", "busy while held", {busy, req_ready}, 2'b10);
            @(negedge clk);
        end
        req_valid = 0;
        while (!rsp_done) @(negedge clk);
        repeat (4) @(negedge clk);
        check(acc_cnt == a0 + 1, "R10", "single access started", acc_cnt, a0 + 1);
        do_access(0, 12'h3BB, 16'h0, q);
        check(q == 16'h0000, "R10", "held write not performed", q, 0);
        do_access(0, 12'h2AA, 16'h0, q);
        check(q == 16'h1111, "R4", "fresh row per access", q, 16'h1111);

        // R7: refresh while idle
        r0 = ref_cnt;
        repeat (3 * REF_IV) @(negedge clk);
        check(ref_cnt >= r0 + 2, "R7", "idle refreshes", ref_cnt, r0 + 2);
        check(max_gap <= GAP_MAX, "R7", "refresh gap idle", max_gap, GAP_MAX);

        // R8: back-to-back traffic does not starve refresh
        r0 = ref_cnt;
        for (int i = 0; i < 40; i++) begin
            do_access(1, ADDR_W'(i * 67), DATA_W'(i * 16'h0101 + 3), q);
            do_access(0, ADDR_W'(i * 67), 16'h0, q);
            if (q != DATA_W'(i * 16'h0101 + 3))
                check(0, "R3", "stream read data", q, DATA_W'(i * 16'h0101 + 3));
        end
        check(ref_cnt >= r0 + 3, "R8", "refresh under load", ref_cnt, r0 + 3);
        check(max_gap <= GAP_MAX, "R8", "refresh gap under load", max_gap, GAP_MAX);
        check_protocol("stream");

        // Timing set B, loaded under reset
        @(negedge clk);
        rst = 1;
        cfg_rcd = 1; cfg_cas = 3; cfg_ras = 3; cfg_acc = 6; cfg_rp = 1;
        repeat (2) @(negedge clk);
        check(rsp_rdata == 0 && !busy, "R11", "second reset clears", rsp_rdata, 0);
        rst = 0;
        do_access(0, 12'h143, 16'h0, q);
        check(q == 16'h5A5A, "R3", "set B long access time", q, 16'h5A5A);
        check(m_row == 6'h05 && m_col == 6'h03, "R2", "set B halves", {m_row, m_col}, 12'h143);
        do_access(1, 12'hFC0, 16'hC3C3, q);
        do_access(0, 12'hFC0, 16'h0, q);
        check(q == 16'hC3C3, "R9", "set B write/read", q, 16'hC3C3);
        repeat (2 * REF_IV) @(negedge clk);
        check(max_gap <= GAP_MAX && ref_cnt > r0 + 3, "R7", "set B refresh", max_gap, GAP_MAX);
        check_protocol("set B");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule